// File: doc/BRIEF.md
# QDR SRAM Double-Rate Port Controller

This block connects a host to a quad-data-rate SRAM whose read and write data travel on separate ports. The host sees full 36-bit words: a write channel (request, address, data) and a read channel (request, address, returned data with a valid pulse). The memory sees 18-bit half-words on three buses: one address bus shared by reads and writes, one write-data bus and one read-data bus. The whole block runs on a fast clock at twice the system rate. Each system cycle is two fast-clock phases, and each memory bus carries one half-word per phase.

A two-state sequencer marks the phase. In `SEQ_LO`, the first phase of a system cycle, host requests are sampled. `SEQ_LO` always moves to `SEQ_HI`, and `SEQ_HI` always moves back to `SEQ_LO`; reset forces `SEQ_LO`. A read and a write may both be accepted on the same `SEQ_LO` edge. The read address goes out in the first phase and the write address in the second. The low write half goes out in the first phase and the high half in the second.

Read data comes back a fixed number of system cycles after the read select, low half first. The halves are captured in boundary registers, reassembled into a 36-bit word and presented with a one-fast-cycle valid pulse. Every memory-facing signal is registered.

Top module: `qdrp_port_ctrl`

## Requirements
- R1: While synchronous reset is sampled high, both memory selects are driven high (inactive), `rd_valid` is low and the sequencer returns to `SEQ_LO`; the first edge after reset release is an accepting edge.
- R2: Host requests are sampled only on `SEQ_LO` edges. A request that is high only across a `SEQ_HI` edge produces no memory select and no read data.
- R3: Each accepted request drives its active-low select (`mem_rsel_n` or `mem_wsel_n`) low for exactly two fast-clock cycles, which is one system cycle, starting right after the accepting edge.
- R4: During an accepted window, `mem_addr` carries the read address in the first fast cycle and the write address in the second.
- R5: During a write window, `mem_wdata` carries write bits 17:0 in the first fast cycle and bits 35:18 in the second.
- R6: `rd_valid` goes high for exactly one fast cycle. It starts 2*RD_LAT+3 fast-clock edges after the accepting edge (7 edges for RD_LAT=2).
- R7: The memory returns the low half in fast cycle 2*RD_LAT after the window start and the high half in the next cycle. `rd_data` is {high half, low half}.
- R8: A read and a write accepted on the same edge are both issued. A read of an address whose write was accepted in an earlier system cycle returns the written 36-bit word.
- R9: Reads accepted on consecutive system cycles each produce their own `rd_valid` pulse, one system cycle apart, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the system rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Host write request |
| wr_addr | input | 18 | Host write address |
| wr_data | input | 36 | Host write word |
| rd_req | input | 1 | Host read request |
| rd_addr | input | 18 | Host read address |
| rd_data | output | 36 | Reassembled read word |
| rd_valid | output | 1 | One-fast-cycle pulse when `rd_data` is new |
| mem_addr | output | 18 | Memory address, read then write per window |
| mem_wdata | output | 18 | Memory write half-word |
| mem_rdata | input | 18 | Memory read half-word |
| mem_rsel_n | output | 1 | Memory read select, active low |
| mem_wsel_n | output | 1 | Memory write select, active low |

## Verification
The bench uses the default parameters: 18-bit halves, 18-bit addresses and a read latency of two system cycles. With these values the return pipeline is seven fast edges deep, so the exact valid edge can be sampled. Its behavioural memory also spaces back-to-back reads so that their returned halves interleave without overlap. A read with a write in the same window, requests held only over the second phase, and a four-deep read burst are all reachable at this depth.

// File: rtl/qdrp_pkg.sv
package qdrp_pkg;
    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_e;
endpackage

// File: rtl/qdrp_seq.sv
module qdrp_seq
    import qdrp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output seq_e state,
    output logic lo_edge
);
    seq_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_LO;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_LO: nxt = SEQ_HI;
            SEQ_HI: nxt = SEQ_LO;
        endcase
    end

    always_comb begin
        lo_edge = (state == SEQ_LO);
    end
endmodule

// File: rtl/qdrp_issue.sv
module qdrp_issue #(
    parameter int HW = 18,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lo_edge,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [2*HW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] mem_addr,
    output logic [HW-1:0] mem_wdata,
    output logic          mem_rsel_n,
    output logic          mem_wsel_n,
    output logic          rd_issue
);
    logic [HW-1:0] wr_hi_q;
    logic [AW-1:0] wr_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_wdata  <= '0;
            wr_hi_q    <= '0;
            wr_addr_q  <= '0;
            mem_rsel_n <= 1'b1;
            mem_wsel_n <= 1'b1;
        end else if (lo_edge) begin
            mem_addr   <= rd_addr;
            mem_wdata  <= wr_data[HW-1:0];
            wr_hi_q    <= wr_data[2*HW-1:HW];
            wr_addr_q  <= wr_addr;
            mem_rsel_n <= ~rd_req;
            mem_wsel_n <= ~wr_req;
        end else begin
            mem_addr   <= wr_addr_q;
            mem_wdata  <= wr_hi_q;
        end
    end

    assign rd_issue = lo_edge & rd_req & ~rst;
endmodule

// File: rtl/qdrp_return.sv
module qdrp_return #(
    parameter int HW     = 18,
    parameter int RD_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_issue,
    input  logic [HW-1:0]   mem_rdata,
    output logic [2*HW-1:0] rd_data,
    output logic            rd_valid
);
    localparam int LO_TAP = 2 * RD_LAT + 1;
    localparam int HI_TAP = LO_TAP + 1;
    localparam int PW     = HI_TAP + 1;

    logic [PW-1:0] pipe_q;
    logic [HW-1:0] rin_q;
    logic [HW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q   <= '0;
            rin_q    <= '0;
            lo_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            pipe_q   <= {pipe_q[PW-2:0], rd_issue};
            rin_q    <= mem_rdata;
            rd_valid <= pipe_q[HI_TAP];
            if (pipe_q[LO_TAP]) lo_q <= rin_q;
            if (pipe_q[HI_TAP]) rd_data <= {rin_q, lo_q};
        end
    end
endmodule

// File: rtl/qdrp_port_ctrl.sv
module qdrp_port_ctrl
    import qdrp_pkg::*;
#(
    parameter int HW     = 18,
    parameter int AW     = 18,
    parameter int RD_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_req,
    input  logic [AW-1:0]   wr_addr,
    input  logic [2*HW-1:0] wr_data,
    input  logic            rd_req,
    input  logic [AW-1:0]   rd_addr,
    output logic [2*HW-1:0] rd_data,
    output logic            rd_valid,
    output logic [AW-1:0]   mem_addr,
    output logic [HW-1:0]   mem_wdata,
    input  logic [HW-1:0]   mem_rdata,
    output logic            mem_rsel_n,
    output logic            mem_wsel_n
);
    seq_e seq_state;
    logic lo_edge;
    logic rd_issue;

    qdrp_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .state   (seq_state),
        .lo_edge (lo_edge)
    );

    qdrp_issue #(.HW(HW), .AW(AW)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .lo_edge    (lo_edge),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rsel_n (mem_rsel_n),
        .mem_wsel_n (mem_wsel_n),
        .rd_issue   (rd_issue)
    );

    qdrp_return #(.HW(HW), .RD_LAT(RD_LAT)) u_ret (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (rd_issue),
        .mem_rdata (mem_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/qdrp_port_ctrl_chk.sv
module qdrp_port_ctrl_chk
    import qdrp_pkg::*;
(
    input logic clk,
    input logic rst,
    input seq_e seq_state,
    input logic wr_req,
    input logic rd_req,
    input logic rd_valid,
    input logic mem_rsel_n,
    input logic mem_wsel_n
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (mem_rsel_n && mem_wsel_n && !rd_valid)); // R1

    AST_RSEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rsel_n) |-> $past(rd_req && seq_state == SEQ_LO)); // R2

    AST_WSEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wsel_n) |-> $past(wr_req && seq_state == SEQ_LO)); // R2

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_HI) |=> ($stable(mem_rsel_n) && $stable(mem_wsel_n))); // R3

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R6
endmodule

bind qdrp_port_ctrl qdrp_port_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .seq_state  (seq_state),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .mem_rsel_n (mem_rsel_n),
    .mem_wsel_n (mem_wsel_n)
);

// File: tb/test_qdrp_port_ctrl.sv
`timescale 1ns/1ps
module test_qdrp_port_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_req = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [17:0] rd_addr = '0;
    logic [35:0] rd_data;
    logic        rd_valid;
    logic [17:0] mem_addr;
    logic [17:0] mem_wdata;
    logic [17:0] mem_rdata = '0;
    logic        mem_rsel_n;
    logic        mem_wsel_n;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    qdrp_port_ctrl i_qdrp_port_ctrl (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rsel_n(mem_rsel_n), .mem_wsel_n(mem_wsel_n)
    );

    // edges since reset release; odd means the interval after an accepting edge
    int ecnt = 0;
    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    // behavioural memory
    logic [35:0] ref_mem [int];
    logic [18:0] slot [8];
    logic [17:0] wlo;
    int ncnt = 0;
    initial for (int i = 0; i < 8; i++) slot[i] = '0;

    always @(negedge clk) begin
        logic [35:0] word;
        mem_rdata = slot[ncnt % 8][18] ? slot[ncnt % 8][17:0] : 18'h0;
        slot[ncnt % 8] = '0;
        if (!rst) begin
            if (ecnt % 2 == 1) begin
                if (!mem_rsel_n) begin
                    word = ref_mem.exists(int'(mem_addr)) ? ref_mem[int'(mem_addr)] : 36'h0;
                    slot[(ncnt + 4) % 8] = {1'b1, word[17:0]};
                    slot[(ncnt + 5) % 8] = {1'b1, word[35:18]};
                end
                if (!mem_wsel_n) wlo = mem_wdata;
            end else if (!mem_wsel_n) begin
                ref_mem[int'(mem_addr)] = {mem_wdata, wlo};
            end
        end
        ncnt++;
    end

    // read-valid monitor
    int vcount = 0;
    logic [35:0] vdata [32];
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            vdata[vcount % 32] = rd_data;
            vcount++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // wait to the negedge just before an accepting edge
    task automatic sync_lo();
        @(negedge clk);
        while (rst || (ecnt % 2 != 0)) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(mem_rsel_n === 1'b1, "R1 rsel", 64'(mem_rsel_n), 1);
        chk(mem_wsel_n === 1'b1, "R1 wsel", 64'(mem_wsel_n), 1);
        chk(rd_valid === 1'b0, "R1 valid", 64'(rd_valid), 0);
    endtask

    task automatic t_write(input logic [17:0] a, input logic [35:0] d);
        sync_lo();
        wr_req = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 0;
        chk(mem_wsel_n === 1'b0, "R3 wsel first", 64'(mem_wsel_n), 0);
        chk(mem_wdata === d[17:0], "R5 low half", 64'(mem_wdata), 64'(d[17:0]));
        @(negedge clk);
        chk(mem_wsel_n === 1'b0, "R3 wsel second", 64'(mem_wsel_n), 0);
        chk(mem_addr === a, "R4 write addr", 64'(mem_addr), 64'(a));
        chk(mem_wdata === d[35:18], "R5 high half", 64'(mem_wdata), 64'(d[35:18]));
        @(negedge clk);
        chk(mem_wsel_n === 1'b1, "R3 wsel release", 64'(mem_wsel_n), 1);
    endtask

    task automatic t_read(input logic [17:0] a, input logic [35:0] exp,
                          input bit with_wr, input logic [17:0] wa, input logic [35:0] wd);
        sync_lo();
        rd_req = 1; rd_addr = a;
        if (with_wr) begin wr_req = 1; wr_addr = wa; wr_data = wd; end
        @(negedge clk);
        rd_req = 0; wr_req = 0;
        chk(mem_rsel_n === 1'b0, "R3 rsel", 64'(mem_rsel_n), 0);
        chk(mem_addr === a, "R4 read addr", 64'(mem_addr), 64'(a));
        if (with_wr) chk(mem_wsel_n === 1'b0, "R8 wsel same window", 64'(mem_wsel_n), 0);
        @(negedge clk);
        if (with_wr) chk(mem_addr === wa, "R4 write addr second", 64'(mem_addr), 64'(wa));
        repeat (5) @(negedge clk);
        chk(rd_valid === 1'b0, "R6 early", 64'(rd_valid), 0);
        @(negedge clk);
        chk(rd_valid === 1'b1, "R6 valid edge", 64'(rd_valid), 1);
        chk(rd_data === exp, "R7 R8 data", 64'(rd_data), 64'(exp));
        @(negedge clk);
        chk(rd_valid === 1'b0, "R6 pulse width", 64'(rd_valid), 0);
    endtask

    task automatic t_ignored();
        int v0;
        v0 = vcount;
        sync_lo();
        @(negedge clk);
        rd_req = 1; wr_req = 1; rd_addr = 18'h11; wr_addr = 18'h11; wr_data = 36'hF_FFFF_FFFF;
        @(negedge clk);
        rd_req = 0; wr_req = 0;
        for (int i = 0; i < 3; i++) begin
            chk(mem_rsel_n === 1'b1 && mem_wsel_n === 1'b1, "R2 no select",
                64'({mem_rsel_n, mem_wsel_n}), 3);
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
        chk(vcount == v0, "R2 no read data", 64'(vcount), 64'(v0));
    endtask

    task automatic t_burst(input logic [17:0] a0, input logic [35:0] e0,
                           input logic [17:0] a1, input logic [35:0] e1);
        int v0;
        logic [17:0] aa [4];
        logic [35:0] ee [4];
        aa[0] = a0; aa[1] = a1; aa[2] = a0; aa[3] = a1;
        ee[0] = e0; ee[1] = e1; ee[2] = e0; ee[3] = e1;
        v0 = vcount;
        sync_lo();
        for (int i = 0; i < 4; i++) begin
            rd_req = 1; rd_addr = aa[i];
            @(negedge clk);
            @(negedge clk);
        end
        rd_req = 0;
        repeat (12) @(negedge clk);
        chk(vcount == v0 + 4, "R9 pulse count", 64'(vcount - v0), 4);
        for (int i = 0; i < 4; i++)
            chk(vdata[(v0 + i) % 32] === ee[i], "R9 order", 64'(vdata[(v0 + i) % 32]), 64'(ee[i]));
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 0;
        t_write(18'h00012, 36'hA_BCDE_F012);
        t_read(18'h00012, 36'hA_BCDE_F012, 0, '0, '0);
        t_read(18'h00012, 36'hA_BCDE_F012, 1, 18'h3FF01, 36'h5_5AA5_0FF0);
        t_read(18'h3FF01, 36'h5_5AA5_0FF0, 0, '0, '0);
        t_ignored();
        t_read(18'h00011, 36'h0, 0, '0, '0);
        t_write(18'h00020, 36'h1_2345_6789);
        t_burst(18'h00012, 36'hA_BCDE_F012, 18'h00020, 36'h1_2345_6789);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule